// File: doc/BRIEF.md
# Serial Baud Rate Tick Generator

This block produces the timing enables for one asynchronous serial channel. A programmable time constant, loaded through byte-wide write lanes, sets a rate counter. That counter emits a one-cycle pulse every time-constant-plus-two reference clocks. An oversampling prescaler then divides those pulses by 1, 16, 32 or 64 to give the bit-period tick that a serializer consumes.

The block also decodes the character-format selection fields into a data-bit count, a parity mode and a stop-bit choice, so that the serializer receives ready-to-use values. Writing either byte of the time constant restarts both counters cleanly. A low enable parks both counters at their starting values.

Top module: `baud_tick_gen`

## Requirements
- R1: The time constant is `tc_wdata` captured per byte lane: `tc_we[0]` loads bits 7:0 and `tc_we[1]` loads bits 15:8, and each lane keeps its value until it is written again. Both lanes reset to 0.
- R2: With `en` high and no writes, `rate_pulse` is high for exactly one cycle in every time-constant-plus-2 cycles.
- R3: A time constant of 0 gives a `rate_pulse` every 2 cycles. No two consecutive cycles carry a pulse for any time constant.
- R4: `bit_tick` is high for one cycle on every Nth rate pulse. N is set by `ovs_sel`: 00 gives 1, 01 gives 16, 10 gives 32 and 11 gives 64. A tick therefore recurs every N*(tc+2) cycles.
- R5: A write on any lane restarts both counters. The first `rate_pulse` comes tc+3 clock edges after the write edge, and the first `bit_tick` comes N*(tc+2)+2 edges after it. No pulse of the old count appears in between.
- R6: While `en` is low, neither `rate_pulse` nor `bit_tick` is asserted and both counters hold their start values. The first `rate_pulse` comes tc+2 edges after the first edge with `en` high.
- R7: `data_bits` decodes `len_sel` as follows: 00 gives 5, 01 gives 7, 10 gives 6 and 11 gives 8.
- R8: `parity_on` equals `par_en`. `parity_even` equals `par_even_sel` when `par_en` is 1 and is 0 otherwise.
- R9: `stop_two` is 1 only when `stop_sel` is 11. Every other value means one stop bit.
- R10: After reset, `rate_pulse` and `bit_tick` are low and the time constant is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Rate generator enable |
| tc_we | input | 2 | Per-byte write strobes for the time constant |
| tc_wdata | input | 16 | Time constant write data |
| ovs_sel | input | 2 | Oversampling factor select |
| par_en | input | 1 | Parity enable field |
| par_even_sel | input | 1 | Even (1) / odd (0) parity field |
| stop_sel | input | 2 | Stop-bit field |
| len_sel | input | 2 | Data-length field |
| rate_pulse | output | 1 | Rate counter output pulse |
| bit_tick | output | 1 | Bit-period tick after the prescaler |
| data_bits | output | 4 | Decoded data-bit count |
| parity_on | output | 1 | Parity in use |
| parity_even | output | 1 | Even parity selected |
| stop_two | output | 1 | Two stop bits selected |

## Verification
The format outputs are combinational and are read in the same cycle that their fields are driven. The pulse timing is measured in clock edges counted from the write edge. The write takes effect on that edge, the reload flag on the next one, and the pulse register one edge after the count reaches zero, which puts the first `rate_pulse` at tc+3 edges. The tick register adds one more edge behind the Nth pulse. Each measurement samples on the falling edge and counts rising edges until the output is seen. The expected counts come from these formulas, taken over every oversampling factor and a range of time constants.

// File: rtl/baud_pkg.sv
package baud_pkg;

   typedef enum logic [1:0] {
      OVS_X1  = 2'b00,
      OVS_X16 = 2'b01,
      OVS_X32 = 2'b10,
      OVS_X64 = 2'b11
   } ovs_e;

   function automatic logic [7:0] ovs_factor(input ovs_e m);
      case (m)
         OVS_X1:  return 8'd1;
         OVS_X16: return 8'd16;
         OVS_X32: return 8'd32;
         default: return 8'd64;
      endcase
   endfunction

endpackage

// File: rtl/baud_tc_reg.sv
module baud_tc_reg #(
   parameter int BYTE_W   = 8,
   parameter int TC_BYTES = 2,
   localparam int TC_W    = BYTE_W * TC_BYTES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [TC_BYTES-1:0] we,
   input  logic [TC_W-1:0]     wdata,
   output logic [TC_W-1:0]     tc,
   output logic                reload
);

   for (genvar b = 0; b < TC_BYTES; b++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= '0;
         else if (we[b])
            lane_q <= wdata[b*BYTE_W +: BYTE_W];
      end
      assign tc[b*BYTE_W +: BYTE_W] = lane_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reload <= 1'b0;
      else
         reload <= |we;
   end

endmodule

// File: rtl/baud_rate_cnt.sv
module baud_rate_cnt #(
   parameter int TC_W   = 16,
   localparam int CNT_W = TC_W + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            reload,
   input  logic [TC_W-1:0] tc,
   output logic            pulse
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] start_val;

   // counting tc+1 down to 0 spans tc+2 cycles
   assign start_val = CNT_W'(tc) + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(1);
         pulse <= 1'b0;
      end else if (!en || reload) begin
         cnt_q <= start_val;
         pulse <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q <= start_val;
         pulse <= 1'b1;
      end else begin
         cnt_q <= cnt_q - CNT_W'(1);
         pulse <= 1'b0;
      end
   end

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
   import baud_pkg::*;
#(
   parameter int MAX_OVS = 64,
   localparam int PW     = $clog2(MAX_OVS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic reload,
   input  ovs_e mode,
   input  logic pulse_in,
   output logic tick
);

   if (MAX_OVS < 64) begin : g_bad_ovs
      $error("MAX_OVS must cover the largest oversampling factor");
   end

   logic [PW-1:0] pcnt_q;
   logic [PW-1:0] limit;

   assign limit = PW'(ovs_factor(mode) - 8'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         tick   <= 1'b0;
      end else if (!en || reload) begin
         pcnt_q <= '0;
         tick   <= 1'b0;
      end else if (pulse_in) begin
         if (pcnt_q >= limit) begin
            pcnt_q <= '0;
            tick   <= 1'b1;
         end else begin
            pcnt_q <= pcnt_q + PW'(1);
            tick   <= 1'b0;
         end
      end else begin
         tick <= 1'b0;
      end
   end

endmodule

// File: rtl/baud_fmt_decode.sv
module baud_fmt_decode (
   input  logic       par_en,
   input  logic       par_even_sel,
   input  logic [1:0] stop_sel,
   input  logic [1:0] len_sel,
   output logic [3:0] data_bits,
   output logic       parity_on,
   output logic       parity_even,
   output logic       stop_two
);

   always_comb begin
      case (len_sel)
         2'b00:   data_bits = 4'd5;
         2'b01:   data_bits = 4'd7;
         2'b10:   data_bits = 4'd6;
         default: data_bits = 4'd8;
      endcase
   end

   assign parity_on   = par_en;
   assign parity_even = par_en & par_even_sel;
   assign stop_two    = (stop_sel == 2'b11);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int TC_BYTES = 2,
   parameter int MAX_OVS  = 64,
   localparam int TC_W    = BYTE_W * TC_BYTES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [TC_BYTES-1:0] tc_we,
   input  logic [TC_W-1:0]     tc_wdata,
   input  logic [1:0]          ovs_sel,
   input  logic                par_en,
   input  logic                par_even_sel,
   input  logic [1:0]          stop_sel,
   input  logic [1:0]          len_sel,
   output logic                rate_pulse,
   output logic                bit_tick,
   output logic [3:0]          data_bits,
   output logic                parity_on,
   output logic                parity_even,
   output logic                stop_two
);

   logic [TC_W-1:0] tc;
   logic            reload;

   baud_tc_reg #(.BYTE_W(BYTE_W), .TC_BYTES(TC_BYTES)) u_tc (
      .clk(clk), .rst_n(rst_n), .we(tc_we), .wdata(tc_wdata),
      .tc(tc), .reload(reload)
   );

   baud_rate_cnt #(.TC_W(TC_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .en(en), .reload(reload),
      .tc(tc), .pulse(rate_pulse)
   );

   baud_prescale #(.MAX_OVS(MAX_OVS)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(en), .reload(reload),
      .mode(ovs_e'(ovs_sel)), .pulse_in(rate_pulse), .tick(bit_tick)
   );

   baud_fmt_decode u_fmt (
      .par_en(par_en), .par_even_sel(par_even_sel), .stop_sel(stop_sel),
      .len_sel(len_sel), .data_bits(data_bits), .parity_on(parity_on),
      .parity_even(parity_even), .stop_two(stop_two)
   );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
   parameter int TC_BYTES = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                en,
   input logic [TC_BYTES-1:0] tc_we,
   input logic                rate_pulse,
   input logic                bit_tick
);

   AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !rate_pulse); // R6

   AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !bit_tick); // R6

   AST_PULSE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      rate_pulse |=> !rate_pulse); // R3

   AST_TICK_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> $past(rate_pulse)); // R4

   AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (|tc_we) |=> ##1 !rate_pulse); // R5

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.TC_BYTES(TC_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .tc_we(tc_we),
   .rate_pulse(rate_pulse), .bit_tick(bit_tick)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [1:0]  tc_we = '0;
   logic [15:0] tc_wdata = '0;
   logic [1:0]  ovs_sel = '0;
   logic        par_en = 1'b0;
   logic        par_even_sel = 1'b0;
   logic [1:0]  stop_sel = '0;
   logic [1:0]  len_sel = '0;
   logic        rate_pulse, bit_tick, parity_on, parity_even, stop_two;
   logic [3:0]  data_bits;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   baud_tick_gen u_baud_tick_gen (
      .clk(clk), .rst_n(rst_n), .en(en), .tc_we(tc_we), .tc_wdata(tc_wdata),
      .ovs_sel(ovs_sel), .par_en(par_en), .par_even_sel(par_even_sel),
      .stop_sel(stop_sel), .len_sel(len_sel), .rate_pulse(rate_pulse),
      .bit_tick(bit_tick), .data_bits(data_bits), .parity_on(parity_on),
      .parity_even(parity_even), .stop_two(stop_two)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // edges counted after the current point until sig is seen high
   task automatic wait_pulse(output int k);
      k = 0;
      do begin
         @(posedge clk); k++;
         @(negedge clk);
      end while (!rate_pulse && k < 20000);
   endtask

   task automatic wait_tick(output int k);
      k = 0;
      do begin
         @(posedge clk); k++;
         @(negedge clk);
      end while (!bit_tick && k < 20000);
   endtask

   task automatic write_tc(input logic [15:0] v);
      @(negedge clk);
      tc_we = 2'b11; tc_wdata = v;
      @(negedge clk);
      tc_we = 2'b00;
   endtask

   function automatic int factor(input int sel);
      return (sel == 0) ? 1 : (8 << sel);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int k, seen;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check("R10 pulse after reset", int'(rate_pulse), 0);
      check("R10 tick after reset", int'(bit_tick), 0);

      // R6: disabled, nothing comes out
      seen = 0;
      repeat (50) begin
         @(negedge clk);
         seen += int'(rate_pulse) + int'(bit_tick);
      end
      check("R6 quiet while disabled", seen, 0);

      // R6 / R10: enable with reset time constant 0
      @(negedge clk) en = 1'b1;
      wait_pulse(k);
      check("R6 R10 first pulse after enable (tc=0)", k, 2);
      wait_pulse(k);
      check("R3 period for tc=0", k, 2);

      // R4 / R5 / R2 sweep
      for (int m = 0; m < 4; m++) begin
         for (int t = 0; t < 10; t++) begin
            @(negedge clk) ovs_sel = 2'(m);
            write_tc(16'(t));
            wait_tick(k);
            check($sformatf("R5 first tick tc=%0d mode=%0d", t, m), k, factor(m)*(t+2)+2);
            wait_tick(k);
            check($sformatf("R4 tick period tc=%0d mode=%0d", t, m), k, factor(m)*(t+2));
         end
      end

      @(negedge clk) ovs_sel = 2'b00;
      for (int t = 0; t < 12; t++) begin
         write_tc(16'(t));
         wait_pulse(k);
         check($sformatf("R5 first pulse tc=%0d", t), k, t+3);
         wait_pulse(k);
         check($sformatf("R2 pulse period tc=%0d", t), k, t+2);
      end

      // R1: byte lanes written separately
      @(negedge clk) tc_we = 2'b01; tc_wdata = 16'hAA05;
      @(negedge clk) tc_we = 2'b10; tc_wdata = 16'h0133;
      @(negedge clk) tc_we = 2'b00;
      wait_pulse(k);
      check("R1 first pulse tc=0x0105", k, 16'h0105+3);
      wait_pulse(k);
      check("R1 period tc=0x0105", k, 16'h0105+2);

      // R5: reload in the middle of a long count
      write_tc(16'd40);
      repeat (15) @(negedge clk);
      write_tc(16'd3);
      wait_pulse(k);
      check("R5 mid-count reload first pulse", k, 6);

      // R6: drop enable mid-count
      @(negedge clk) en = 1'b0;
      seen = 0;
      repeat (30) begin
         @(negedge clk);
         seen += int'(rate_pulse) + int'(bit_tick);
      end
      check("R6 quiet after disable", seen, 0);
      @(negedge clk) en = 1'b1;
      wait_pulse(k);
      check("R6 first pulse after re-enable tc=3", k, 5);

      // R7 R8 R9 exhaustive format decode
      for (int f = 0; f < 64; f++) begin
         @(negedge clk);
         len_sel = 2'(f); stop_sel = 2'(f >> 2);
         par_en = f[4]; par_even_sel = f[5];
         #1;
         check("R7 data bits", int'(data_bits),
               5 + (f[0] ? 2 : 0) + (f[1] ? 1 : 0));
         check("R8 parity on", int'(parity_on), int'(f[4]));
         check("R8 parity even", int'(parity_even), (f[4] && f[5]) ? 1 : 0);
         check("R9 stop two", int'(stop_two), ((f >> 2) % 4 == 3) ? 1 : 0);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule